// File: doc/BRIEF.md
# Debug Watchpoint and Breakpoint Unit

This unit watches two bus streams: instruction fetches and load/store accesses. Each stream carries a valid strobe. It raises watchpoint events when the traffic meets programmed conditions. There are eight comparators in all:

- Four compare the instruction fetch address.
- Two compare the load/store address.
- Two compare the load/store data.

Each comparator holds a reference value and a two-bit condition. Pairs of address comparators can be fused into an inside-range or outside-range test. A load/store watchpoint can also be made to require a data match in the same access.

The six watchpoint lines leave the block one cycle after the qualifying strobe. Each line also feeds its own breakpoint channel. A channel is a small state machine with two states:

- `BP_OFF`: disarmed. While in this state the channel keeps loading its count preset.
- `BP_ARMED`: counting. Each watchpoint event decrements the remaining count. When an event arrives with the remaining count at zero, the channel emits a one-cycle breakpoint request and reloads the preset.

The channel has two named transitions:

- "arm" (`BP_OFF` to `BP_ARMED`) is taken on any cycle where the channel enable is high.
- "disarm" (`BP_ARMED` to `BP_OFF`) is taken on any cycle where the channel enable is low.

In `BP_ARMED`, the "count" self-transition decrements the remaining count. The "fire" self-transition pulses the request and reloads the count.

Configuration is given as static inputs from surrounding debug control logic.

Top module: `wpt_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `wp_o` and `bp_o` are all zero.
- R2: Condition code per comparator: 00 bus value equals reference, 01 not equal, 10 bus value less than reference, 11 bus value greater than reference, all unsigned.
- R3: With an instruction pair in solo mode (00 or 11), comparator i drives `wp_o[i]` (i = 0..3). The bit is high in the cycle after a cycle with `if_valid` high, and never without a preceding `if_valid`.
- R4: Instruction pair p (comparators 2p, 2p+1, mode in `ia_pair[2p+1:2p]`) in inside mode 01 drives `wp_o[2p]` with the AND of both comparators and holds `wp_o[2p+1]` low.
- R5: Instruction pair mode 10 (outside) drives `wp_o[2p]` with the OR of both comparators and holds `wp_o[2p+1]` low.
- R6: The load/store address comparators 0 and 1 form a pair with the same three modes, selected by `la_pair`, and drive `wp_o[4]` and `wp_o[5]`. These bits are high only in the cycle after `ls_valid` was high.
- R7: When `ls_qual[k]` is set, `wp_o[4+k]` also requires load/store data comparator k to match in the same access.
- R8: A breakpoint channel whose `bp_en` bit is low never raises its `bp_o` bit.
- R9: A channel armed with count N (field `bp_cnt[CW*j +: CW]`) pulses `bp_o[j]` for one cycle on every (N+1)-th event of `wp_o[j]`. The pulse comes in the same cycle as that `wp_o[j]` bit, and the count then reloads.
- R10: A count of zero raises `bp_o[j]` on every event of `wp_o[j]`.
- R11: Clearing `bp_en[j]` discards the count progress; re-arming restarts from the preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid | input | 1 | Instruction fetch strobe |
| if_addr | input | AW | Instruction fetch address |
| ls_valid | input | 1 | Load/store access strobe |
| ls_addr | input | AW | Load/store address |
| ls_data | input | DW | Load/store data |
| ia_ref | input | 4*AW | Instruction comparator references, comparator i at [AW*i +: AW] |
| ia_cond | input | 8 | Instruction comparator conditions, two bits each |
| ia_pair | input | 4 | Instruction pair modes, two bits per pair |
| la_ref | input | 2*AW | Load/store address references |
| la_cond | input | 4 | Load/store address conditions |
| la_pair | input | 2 | Load/store address pair mode |
| ld_ref | input | 2*DW | Load/store data references |
| ld_cond | input | 4 | Load/store data conditions |
| ls_qual | input | 2 | Data qualification per load/store watchpoint |
| bp_en | input | 6 | Breakpoint channel enables |
| bp_cnt | input | 6*CW | Breakpoint count presets |
| wp_o | output | 6 | Watchpoint lines |
| bp_o | output | 6 | Breakpoint request pulses |

## Verification
The assertions check the following on every cycle:

- No instruction or load/store watchpoint appears without the matching strobe a cycle earlier.
- A fused pair never drives its upper line.
- A breakpoint pulse always coincides with its watchpoint line.
- A breakpoint pulse never comes from a channel that was disabled.

Only the bench scenarios can show the following:

- The condition semantics at and around the reference value.
- The range fusion results.
- The data qualification.
- The exact event count at which a breakpoint fires.
- The restart of counting after disarm.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

    typedef enum logic [1:0] {
        CND_EQ = 2'b00,
        CND_NE = 2'b01,
        CND_LT = 2'b10,
        CND_GT = 2'b11
    } cnd_e;

    typedef enum logic [1:0] {
        PAIR_SOLO = 2'b00,
        PAIR_IN   = 2'b01,
        PAIR_OUT  = 2'b10,
        PAIR_RSV  = 2'b11
    } pair_e;

    typedef enum logic {
        BP_OFF   = 1'b0,
        BP_ARMED = 1'b1
    } bp_st_e;

endpackage

// File: rtl/wpt_cmp.sv
module wpt_cmp
    import wpt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] bus_val,
    input  logic [W-1:0] ref_val,
    input  logic [1:0]   cond,
    output logic         hit
);

    always_comb begin
        unique case (cnd_e'(cond))
            CND_EQ: hit = (bus_val == ref_val);
            CND_NE: hit = (bus_val != ref_val);
            CND_LT: hit = (bus_val <  ref_val);
            CND_GT: hit = (bus_val >  ref_val);
        endcase
    end

endmodule

// File: rtl/wpt_pair.sv
module wpt_pair
    import wpt_pkg::*;
(
    input  logic       hit_a,
    input  logic       hit_b,
    input  logic [1:0] mode,
    output logic       out_lo,
    output logic       out_hi
);

    always_comb begin
        unique case (pair_e'(mode))
            PAIR_IN: begin
                out_lo = hit_a & hit_b;
                out_hi = 1'b0;
            end
            PAIR_OUT: begin
                out_lo = hit_a | hit_b;
                out_hi = 1'b0;
            end
            PAIR_SOLO, PAIR_RSV: begin
                out_lo = hit_a;
                out_hi = hit_b;
            end
        endcase
    end

endmodule

// File: rtl/wpt_bpcnt.sv
module wpt_bpcnt
    import wpt_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] preset,
    input  logic          hit,
    output logic          fire
);

    bp_st_e        state_q;
    bp_st_e        state_d;
    logic [CW-1:0] rem_q;

    // next-state logic: arm / disarm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BP_OFF:   if (en)  state_d = BP_ARMED;
            BP_ARMED: if (!en) state_d = BP_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BP_OFF;
        else        state_q <= state_d;
    end

    // outputs and remaining-count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            unique case (state_q)
                BP_OFF: rem_q <= preset;
                BP_ARMED: begin
                    if (en && hit) begin
                        if (rem_q == '0) begin
                            fire  <= 1'b1;
                            rem_q <= preset;
                        end else begin
                            rem_q <= rem_q - 1'b1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/wpt_top.sv
module wpt_top
    import wpt_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            if_valid,
    input  logic [AW-1:0]   if_addr,
    input  logic            ls_valid,
    input  logic [AW-1:0]   ls_addr,
    input  logic [DW-1:0]   ls_data,
    input  logic [4*AW-1:0] ia_ref,
    input  logic [7:0]      ia_cond,
    input  logic [3:0]      ia_pair,
    input  logic [2*AW-1:0] la_ref,
    input  logic [3:0]      la_cond,
    input  logic [1:0]      la_pair,
    input  logic [2*DW-1:0] ld_ref,
    input  logic [3:0]      ld_cond,
    input  logic [1:0]      ls_qual,
    input  logic [5:0]      bp_en,
    input  logic [6*CW-1:0] bp_cnt,
    output logic [5:0]      wp_o,
    output logic [5:0]      bp_o
);

    localparam int N_IA  = 4;
    localparam int N_LS  = 2;
    localparam int N_WP  = N_IA + N_LS;
    localparam int N_IAP = N_IA / 2;

    logic [N_IA-1:0] ia_hit;
    logic [N_IA-1:0] ia_comb;
    logic [N_LS-1:0] la_hit;
    logic [N_LS-1:0] la_comb;
    logic [N_LS-1:0] ld_hit;
    logic [N_WP-1:0] ev_d;
    logic [N_WP-1:0] wp_q;

    genvar gi;

    generate
        for (gi = 0; gi < N_IA; gi++) begin : g_ia
            wpt_cmp #(.W(AW)) u_cmp (
                .bus_val (if_addr),
                .ref_val (ia_ref[AW*gi +: AW]),
                .cond    (ia_cond[2*gi +: 2]),
                .hit     (ia_hit[gi])
            );
        end

        for (gi = 0; gi < N_IAP; gi++) begin : g_iap
            wpt_pair u_pair (
                .hit_a  (ia_hit[2*gi]),
                .hit_b  (ia_hit[2*gi+1]),
                .mode   (ia_pair[2*gi +: 2]),
                .out_lo (ia_comb[2*gi]),
                .out_hi (ia_comb[2*gi+1])
            );
        end

        for (gi = 0; gi < N_LS; gi++) begin : g_ls
            wpt_cmp #(.W(AW)) u_acmp (
                .bus_val (ls_addr),
                .ref_val (la_ref[AW*gi +: AW]),
                .cond    (la_cond[2*gi +: 2]),
                .hit     (la_hit[gi])
            );
            wpt_cmp #(.W(DW)) u_dcmp (
                .bus_val (ls_data),
                .ref_val (ld_ref[DW*gi +: DW]),
                .cond    (ld_cond[2*gi +: 2]),
                .hit     (ld_hit[gi])
            );
        end
    endgenerate

    wpt_pair u_lspair (
        .hit_a  (la_hit[0]),
        .hit_b  (la_hit[1]),
        .mode   (la_pair),
        .out_lo (la_comb[0]),
        .out_hi (la_comb[1])
    );

    always_comb begin
        ev_d[N_IA-1:0] = ia_comb & {N_IA{if_valid}};
        for (int k = 0; k < N_LS; k++) begin
            ev_d[N_IA+k] = ls_valid & la_comb[k] & (~ls_qual[k] | ld_hit[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wp_q <= '0;
        else        wp_q <= ev_d;
    end

    assign wp_o = wp_q;

    generate
        for (gi = 0; gi < N_WP; gi++) begin : g_bp
            wpt_bpcnt #(.CW(CW)) u_bp (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (bp_en[gi]),
                .preset (bp_cnt[CW*gi +: CW]),
                .hit    (ev_d[gi]),
                .fire   (bp_o[gi])
            );
        end
    endgenerate

endmodule

// File: rtl/wpt_chk.sv
module wpt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       if_valid,
    input logic       ls_valid,
    input logic [3:0] ia_pair,
    input logic [1:0] la_pair,
    input logic [5:0] bp_en,
    input logic [5:0] wp_o,
    input logic [5:0] bp_o
);

    // R3: instruction watchpoints only follow an instruction strobe
    a_r3_ia_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (|wp_o[3:0]) |-> $past(if_valid));

    // R6: load/store watchpoints only follow a load/store strobe
    a_r6_ls_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (|wp_o[5:4]) |-> $past(ls_valid));

    // R4 / R5: a fused instruction pair keeps its upper line low
    a_r4_pair0_upper_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ia_pair[1:0]) == 2'b01 || $past(ia_pair[1:0]) == 2'b10) |-> !wp_o[1]);

    a_r5_pair1_upper_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ia_pair[3:2]) == 2'b01 || $past(ia_pair[3:2]) == 2'b10) |-> !wp_o[3]);

    // R6: a fused load/store pair keeps its upper line low
    a_r6_lspair_upper_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(la_pair) == 2'b01 || $past(la_pair) == 2'b10) |-> !wp_o[5]);

    // R9: a breakpoint pulse coincides with its watchpoint line
    a_r9_bp_with_wp: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_o & ~wp_o) == 6'b0);

    // R8: a disabled channel never requests a breakpoint
    a_r8_bp_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_o & ~$past(bp_en)) == 6'b0);

endmodule

bind wpt_top wpt_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .if_valid (if_valid),
    .ls_valid (ls_valid),
    .ia_pair  (ia_pair),
    .la_pair  (la_pair),
    .bp_en    (bp_en),
    .wp_o     (wp_o),
    .bp_o     (bp_o)
);

// File: tb/sim_wpt_top.sv
module sim_wpt_top;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            if_valid = 1'b0;
    logic [AW-1:0]   if_addr = '0;
    logic            ls_valid = 1'b0;
    logic [AW-1:0]   ls_addr = '0;
    logic [DW-1:0]   ls_data = '0;
    logic [4*AW-1:0] ia_ref = '0;
    logic [7:0]      ia_cond = '0;
    logic [3:0]      ia_pair = '0;
    logic [2*AW-1:0] la_ref = '0;
    logic [3:0]      la_cond = '0;
    logic [1:0]      la_pair = '0;
    logic [2*DW-1:0] ld_ref = '0;
    logic [3:0]      ld_cond = '0;
    logic [1:0]      ls_qual = '0;
    logic [5:0]      bp_en = '0;
    logic [6*CW-1:0] bp_cnt = '0;
    logic [5:0]      wp_o;
    logic [5:0]      bp_o;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    wpt_top #(.AW(AW), .DW(DW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .if_valid(if_valid), .if_addr(if_addr),
        .ls_valid(ls_valid), .ls_addr(ls_addr), .ls_data(ls_data),
        .ia_ref(ia_ref), .ia_cond(ia_cond), .ia_pair(ia_pair),
        .la_ref(la_ref), .la_cond(la_cond), .la_pair(la_pair),
        .ld_ref(ld_ref), .ld_cond(ld_cond), .ls_qual(ls_qual),
        .bp_en(bp_en), .bp_cnt(bp_cnt),
        .wp_o(wp_o), .bp_o(bp_o)
    );

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic fetch(input logic [AW-1:0] a, input logic v);
        @(negedge clk);
        if_valid = v;
        if_addr  = a;
        @(negedge clk);
        if_valid = 1'b0;
    endtask

    task automatic access(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        ls_valid = 1'b1;
        ls_addr  = a;
        ls_data  = d;
        @(negedge clk);
        ls_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 in reset wp", wp_o, 6'b0);
        chk("R1 in reset bp", bp_o, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", wp_o | bp_o, 6'b0);
    endtask

    task automatic t_conds;
        ia_ref  = {4{32'h0000_0100}};
        ia_cond = {2'b11, 2'b10, 2'b01, 2'b00}; // c3 GT, c2 LT, c1 NE, c0 EQ
        ia_pair = 4'b0000;
        fetch(32'h100, 1'b1); chk("R2 R3 equal addr", wp_o, 6'b000001);
        fetch(32'h080, 1'b1); chk("R2 R3 below ref", wp_o, 6'b000110);
        fetch(32'h200, 1'b1); chk("R2 R3 above ref", wp_o, 6'b001010);
        fetch(32'h100, 1'b0); chk("R3 no strobe", wp_o, 6'b000000);
    endtask

    task automatic t_ranges;
        ia_ref  = {32'h200, 32'h100, 32'h200, 32'h100};
        ia_cond = {2'b11, 2'b10, 2'b10, 2'b11}; // pair0 GT lo/LT hi, pair1 LT lo/GT hi
        ia_pair = 4'b1001;                     // pair1 outside, pair0 inside
        fetch(32'h180, 1'b1); chk("R4 inside hit", wp_o, 6'b000001);
        fetch(32'h200, 1'b1); chk("R4 R5 upper bound", wp_o, 6'b000000);
        fetch(32'h300, 1'b1); chk("R5 outside above", wp_o, 6'b000100);
        fetch(32'h050, 1'b1); chk("R5 outside below", wp_o, 6'b000100);
        ia_pair = 4'b0000;
    endtask

    task automatic t_ls;
        la_ref  = {32'h5000, 32'h4000};
        la_cond = 4'b0000;
        la_pair = 2'b00;
        ld_ref  = {32'h10, 32'hAA};
        ld_cond = {2'b11, 2'b00};
        ls_qual = 2'b10;
        access(32'h4000, 32'h0);  chk("R6 solo ls addr", wp_o, 6'b010000);
        access(32'h5000, 32'h5);  chk("R7 qual data miss", wp_o, 6'b000000);
        access(32'h5000, 32'h20); chk("R7 qual data hit", wp_o, 6'b100000);
        la_cond = {2'b10, 2'b11};
        la_pair = 2'b01;
        ls_qual = 2'b01;
        access(32'h4800, 32'hAA); chk("R6 R7 range and data", wp_o, 6'b010000);
        access(32'h4800, 32'hAB); chk("R7 range data miss", wp_o, 6'b000000);
        access(32'h6000, 32'hAA); chk("R6 out of range", wp_o, 6'b000000);
        la_pair = 2'b00;
        ls_qual = 2'b00;
    endtask

    task automatic t_bp;
        ia_ref  = {4{32'h100}};
        ia_cond = 8'h00;
        ia_pair = 4'b0000;
        bp_en   = 6'b0;
        bp_cnt  = '0;
        bp_cnt[CW*0 +: CW] = 8'd2;
        fetch(32'h100, 1'b1);
        chk("R8 wp while disabled", wp_o, 6'b001111);
        chk("R8 no bp while disabled", bp_o, 6'b0);
        bp_en = 6'b000001;
        idle(2);
        for (int n = 1; n <= 6; n++) begin
            fetch(32'h100, 1'b1);
            chk("R9 count 2 events", bp_o, (n % 3 == 0) ? 6'b000001 : 6'b000000);
        end
        idle(1);
        chk("R9 single cycle pulse", bp_o, 6'b0);
        bp_en = 6'b000010;
        idle(2);
        for (int n = 0; n < 3; n++) begin
            fetch(32'h100, 1'b1);
            chk("R10 zero count every event", bp_o, 6'b000010);
        end
        bp_en = 6'b000001;
        idle(2);
        fetch(32'h100, 1'b1); chk("R11 first partial", bp_o, 6'b0);
        fetch(32'h100, 1'b1); chk("R11 second partial", bp_o, 6'b0);
        bp_en = 6'b0;
        idle(2);
        bp_en = 6'b000001;
        idle(2);
        fetch(32'h100, 1'b1); chk("R11 restart one", bp_o, 6'b0);
        fetch(32'h100, 1'b1); chk("R11 restart two", bp_o, 6'b0);
        fetch(32'h100, 1'b1); chk("R11 restart fires", bp_o, 6'b000001);
        bp_en = 6'b0;
    endtask

    initial begin
        t_reset();
        t_conds();
        t_ranges();
        t_ls();
        t_bp();
        idle(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule